// File: doc/BRIEF.md
# Timed Lock and Fuse Access Controller

This block guards the privileged path to a device's non-volatile configuration: six lock bits held in a register, plus three fuse bytes supplied on input pins. Software opens a short access window by writing one specific value to a control register. The following store strobe or load strobe is honoured only if it arrives a few cycles after that write. The window then closes by itself, either after one honoured strobe or once its last cycle passes unused. A store strobe lowers boot lock bits. A load strobe returns one of four configuration bytes, chosen by the two low bits of a 16-bit pointer.

The result of a load is registered. It appears one cycle after the strobe, together with a flag that tells the core to take this byte in place of the normal flash read data. While an EEPROM write is in progress, no access is allowed: no window can be opened and no strobe is honoured.

Top module: `nvcfg_access`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_sel` is 0, `rd_data` is 0x00 and `lock_bits` equals the parameter `LOCK_INIT`, which defaults to all ones.
- R2: A control write opens the window when bits 6..0 of the written value equal 0b0001001. Bit 7 of the written value has no effect. A control write with any other value closes the window, and so does any control write while `ee_busy` is high.
- R3: Take the cycle of the opening write as cycle 0. A load strobe is honoured only in cycles 1 to 3. One cycle after an honoured load, `rd_sel` is 1 for exactly one cycle. In every cycle where `rd_sel` is 0, `rd_data` is 0x00.
- R4: A store strobe is honoured only in cycles 1 to 4 after the opening write.
- R5: For an honoured load, pointer 0x0000 returns `fuse_lo`, 0x0001 returns the lock byte, 0x0002 returns `fuse_ext` and 0x0003 returns `fuse_hi`. A load strobe with any other pointer value is not honoured and leaves the window open.
- R6: The lock byte is {2'b11, lock_bits}. In `lock_bits`, bit 5 and bit 4 are the boot lock bits for the boot section, bit 3 and bit 2 are the boot lock bits for the application section, and bits 1..0 are the general lock bits.
- R7: An honoured store clears each bit k of `lock_bits`, for k in 2..5, whose `lock_wdata` bit k is 0. No lock bit ever changes from 0 to 1. Bits 1..0 never change. The pointer value has no effect on a store.
- R8: After one honoured strobe the window is closed, so a second strobe is ignored. After cycle 4 with no honoured strobe the window is also closed.
- R9: A strobe in a cycle where `ee_busy` is high is ignored, and the window keeps counting.
- R10: An opening write made while a window is already open restarts the count from cycle 0.
- R11: If a store strobe and a load strobe are both valid in the same cycle, the store is honoured and the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| st_strobe | input | 1 | Store-program strobe (lock programming) |
| ld_strobe | input | 1 | Load-program strobe (configuration readback) |
| ptr | input | 16 | Pointer address that selects the readback byte |
| lock_wdata | input | 8 | Data byte for lock programming |
| ee_busy | input | 1 | High while an EEPROM write is in progress |
| fuse_lo | input | 8 | Fuse low byte |
| fuse_hi | input | 8 | Fuse high byte |
| fuse_ext | input | 8 | Extended fuse byte |
| rd_data | output | 8 | Readback byte, 0x00 when not selected |
| rd_sel | output | 1 | Use `rd_data` in place of normal flash data |
| lock_bits | output | 6 | Current lock register |

## Verification
Strobes are placed at every offset from cycle 1 to cycle 5 after an opening write. This separates the three-cycle read limit from the four-cycle write limit, and it shows both an off-by-one edge and a missed expiry. Loads are tried with each of the four valid pointer values and with pointers whose upper bits are set, which tells a wrong byte mapping apart from an incomplete address decode. Stores use data bytes that have a single zero bit at a boot position, at a general-lock position, and with a nonzero pointer, which isolates the masking rule. A random phase interleaves re-arming, non-matching control values, busy cycles and collisions between a store and a load, against a reference model of the window.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;

  // Byte chosen by the two low pointer bits during a readback.
  typedef enum logic [1:0] {
    SEL_FUSE_LO  = 2'd0,
    SEL_LOCK     = 2'd1,
    SEL_FUSE_EXT = 2'd2,
    SEL_FUSE_HI  = 2'd3
  } cfg_sel_e;

  localparam int          LOCK_W    = 6;
  localparam logic [7:0]  ARM_VALUE = 8'h09;
  localparam logic [7:0]  ARM_CARE  = 8'h7F;  // bit 7 is don't-care
  localparam logic [7:0]  BOOT_MASK = 8'h3C;  // lock bits software may lower

  function automatic logic is_arm(input logic [7:0] v);
    return (v & ARM_CARE) == ARM_VALUE;
  endfunction

endpackage

// File: rtl/nvcfg_arm_window.sv
module nvcfg_arm_window
  import nvcfg_pkg::*;
#(
  parameter int WR_WIN = 4,
  parameter int RD_WIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       ee_busy,
  input  logic       st_strobe,
  input  logic       ld_strobe,
  input  logic       addr_ok,
  output logic       st_go,
  output logic       ld_go
);

  localparam int LAST = ((WR_WIN > RD_WIN) ? WR_WIN : RD_WIN) - 1;
  localparam int AW   = (LAST < 1) ? 1 : $clog2(LAST + 1);

  logic          armed_q, armed_d;
  logic [AW-1:0] age_q, age_d;
  logic          upd_en;

  always_comb begin
    st_go = armed_q && st_strobe && !ee_busy && (int'(age_q) < WR_WIN);
    ld_go = armed_q && ld_strobe && !ee_busy && addr_ok
            && (int'(age_q) < RD_WIN) && !st_go;
  end

  always_comb begin
    armed_d = armed_q;
    age_d   = age_q;
    if (ctl_we) begin
      armed_d = is_arm(ctl_wdata) && !ee_busy;
      age_d   = '0;
    end else if (st_go || ld_go) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (age_q == AW'(LAST)) armed_d = 1'b0;
      else                    age_d   = age_q + 1'b1;
    end
  end

  assign upd_en = ctl_we || armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      age_q   <= age_d;
    end
  end

endmodule

// File: rtl/nvcfg_lock_store.sv
module nvcfg_lock_store
  import nvcfg_pkg::*;
#(
  parameter logic [LOCK_W-1:0] LOCK_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_go,
  input  logic [7:0]        lock_wdata,
  output logic [LOCK_W-1:0] lock_q
);

  logic [LOCK_W-1:0] lock_d;

  // A zero data bit at a boot position programs (clears) that bit.
  always_comb begin
    lock_d = lock_q & ~LOCK_W'(BOOT_MASK & ~lock_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= LOCK_INIT;
    else if (st_go) lock_q <= lock_d;
  end

endmodule

// File: rtl/nvcfg_readback.sv
module nvcfg_readback
  import nvcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_go,
  input  logic [1:0]        sel,
  input  logic [7:0]        fuse_lo,
  input  logic [7:0]        fuse_hi,
  input  logic [7:0]        fuse_ext,
  input  logic [LOCK_W-1:0] lock_q,
  output logic [7:0]        rd_data,
  output logic              rd_sel
);

  logic [7:0] pick;
  logic [7:0] data_d;
  logic       sel_d;

  always_comb begin
    unique case (cfg_sel_e'(sel))
      SEL_FUSE_LO:  pick = fuse_lo;
      SEL_LOCK:     pick = {{(8 - LOCK_W){1'b1}}, lock_q};
      SEL_FUSE_EXT: pick = fuse_ext;
      SEL_FUSE_HI:  pick = fuse_hi;
      default:      pick = fuse_lo;
    endcase
    sel_d  = ld_go;
    data_d = ld_go ? pick : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel  <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      rd_sel  <= sel_d;
      rd_data <= data_d;
    end
  end

endmodule

// File: rtl/nvcfg_access.sv
module nvcfg_access
  import nvcfg_pkg::*;
#(
  parameter int                WR_WIN    = 4,
  parameter int                RD_WIN    = 3,
  parameter logic [LOCK_W-1:0] LOCK_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              st_strobe,
  input  logic              ld_strobe,
  input  logic [15:0]       ptr,
  input  logic [7:0]        lock_wdata,
  input  logic              ee_busy,
  input  logic [7:0]        fuse_lo,
  input  logic [7:0]        fuse_hi,
  input  logic [7:0]        fuse_ext,
  output logic [7:0]        rd_data,
  output logic              rd_sel,
  output logic [LOCK_W-1:0] lock_bits
);

  logic addr_ok;
  logic st_go;
  logic ld_go;

  assign addr_ok = (ptr[15:2] == 14'd0);

  nvcfg_arm_window #(.WR_WIN(WR_WIN), .RD_WIN(RD_WIN)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ee_busy   (ee_busy),
    .st_strobe (st_strobe),
    .ld_strobe (ld_strobe),
    .addr_ok   (addr_ok),
    .st_go     (st_go),
    .ld_go     (ld_go)
  );

  nvcfg_lock_store #(.LOCK_INIT(LOCK_INIT)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_go      (st_go),
    .lock_wdata (lock_wdata),
    .lock_q     (lock_bits)
  );

  nvcfg_readback u_rdback (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_go    (ld_go),
    .sel      (ptr[1:0]),
    .fuse_lo  (fuse_lo),
    .fuse_hi  (fuse_hi),
    .fuse_ext (fuse_ext),
    .lock_q   (lock_bits),
    .rd_data  (rd_data),
    .rd_sel   (rd_sel)
  );

endmodule

// File: rtl/nvcfg_access_chk.sv
module nvcfg_access_chk #(
  parameter int WR_WIN = 4,
  parameter int RD_WIN = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [7:0]  ctl_wdata,
  input logic        st_strobe,
  input logic        ld_strobe,
  input logic [15:0] ptr,
  input logic        ee_busy,
  input logic [7:0]  rd_data,
  input logic        rd_sel,
  input logic [5:0]  lock_bits
);

  // Port-level tracker: cycles since the last control write, and whether it armed.
  logic       seen_arm;
  logic [3:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_arm <= 1'b0;
      since    <= 4'd0;
    end else if (ctl_we) begin
      seen_arm <= ((ctl_wdata & 8'h7F) == 8'h09) && !ee_busy;
      since    <= 4'd0;
    end else if (since != 4'hF) begin
      since    <= since + 4'd1;
    end
  end

  assert_load_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> $past(ld_strobe && !ee_busy && seen_arm && (int'(since) < RD_WIN)
                     && (ptr[15:2] == 14'd0)));

  assert_idle_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data == 8'h00));

  assert_store_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits != $past(lock_bits)) |->
      $past(st_strobe && !ee_busy && seen_arm && (int'(since) < WR_WIN)));

  assert_lock_readback_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && ($past(ptr[1:0]) == 2'd1)) |-> (rd_data[7:6] == 2'b11));

  assert_lock_one_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits & ~$past(lock_bits)) == 6'd0);

  assert_general_lock_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lock_bits[1:0]));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ee_busy) |-> (!rd_sel && $stable(lock_bits)));

endmodule

bind nvcfg_access nvcfg_access_chk #(.WR_WIN(WR_WIN), .RD_WIN(RD_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .st_strobe (st_strobe),
  .ld_strobe (ld_strobe),
  .ptr       (ptr),
  .ee_busy   (ee_busy),
  .rd_data   (rd_data),
  .rd_sel    (rd_sel),
  .lock_bits (lock_bits)
);

// File: tb/test_nvcfg_access.sv
module test_nvcfg_access;

  localparam int         CLK_PERIOD = 10;
  localparam int         WR = 4;
  localparam int         RD = 3;
  localparam logic [7:0] FL = 8'h5E;
  localparam logic [7:0] FH = 8'hD9;
  localparam logic [7:0] FE = 8'hF4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we, st_strobe, ld_strobe, ee_busy;
  logic [7:0]  ctl_wdata, lock_wdata;
  logic [15:0] ptr;
  logic [7:0]  rd_data;
  logic        rd_sel;
  logic [5:0]  lock_bits;

  int n_vec  = 0;
  int n_fail = 0;

  // reference model state
  bit         m_armed;
  int         m_age;
  logic [5:0] m_lock;
  logic       m_rdsel;
  logic [7:0] m_rddata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nvcfg_access i_nvcfg_access (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .st_strobe(st_strobe), .ld_strobe(ld_strobe), .ptr(ptr),
    .lock_wdata(lock_wdata), .ee_busy(ee_busy),
    .fuse_lo(FL), .fuse_hi(FH), .fuse_ext(FE),
    .rd_data(rd_data), .rd_sel(rd_sel), .lock_bits(lock_bits)
  );

  function automatic logic [7:0] exp_byte(input logic [1:0] s, input logic [5:0] lk);
    case (s)
      2'd0:    return FL;
      2'd1:    return {2'b11, lk};
      2'd2:    return FE;
      default: return FH;
    endcase
  endfunction

  task automatic compare(input string tag);
    n_vec++;
    if (rd_sel !== m_rdsel || rd_data !== m_rddata || lock_bits !== m_lock) begin
      n_fail++;
      $display("FAIL %s: rd_sel=%b rd_data=%h lock=%b, expected rd_sel=%b rd_data=%h lock=%b",
               tag, rd_sel, rd_data, lock_bits, m_rdsel, m_rddata, m_lock);
    end
  endtask

  task automatic drive(input logic we, input logic [7:0] wd, input logic st,
                       input logic ld, input logic [15:0] p, input logic [7:0] lw,
                       input logic busy);
    ctl_we = we; ctl_wdata = wd; st_strobe = st; ld_strobe = ld;
    ptr = p; lock_wdata = lw; ee_busy = busy;
  endtask

  // Apply the driven inputs for one cycle, advance the model, check at the next negedge.
  task automatic step(input string tag);
    bit acc_st, acc_ld;
    logic [7:0] val;
    acc_st = m_armed && st_strobe && !ee_busy && (m_age < WR);
    acc_ld = m_armed && ld_strobe && !ee_busy && (m_age < RD)
             && (ptr[15:2] == 14'd0) && !acc_st;
    val = exp_byte(ptr[1:0], m_lock);
    m_rdsel  = acc_ld;
    m_rddata = acc_ld ? val : 8'h00;
    if (acc_st) m_lock = m_lock & {lock_wdata[5:2], 2'b11};
    if (ctl_we) begin
      m_armed = ((ctl_wdata & 8'h7F) == 8'h09) && !ee_busy;
      m_age   = 0;
    end else if (acc_st || acc_ld) begin
      m_armed = 0;
    end else if (m_armed) begin
      if (m_age == WR - 1) m_armed = 0;
      else                 m_age++;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    drive(0, 8'h00, 0, 0, 16'h0, 8'hFF, 0);
    step(tag);
  endtask

  task automatic arm(input string tag);
    drive(1, 8'h09, 0, 0, 16'h0, 8'hFF, 0);
    step(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 8'h00, 0, 0, 16'h0, 8'hFF, 0);
    m_armed = 0; m_age = 0; m_lock = 6'h3F; m_rdsel = 0; m_rddata = 8'h00;
    repeat (3) @(negedge clk);
    compare("R1 reset asserted");
    rst_n = 1'b1;
    idle("R1 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R1 watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R5 R6: each pointer value returns its byte
    for (int s = 0; s < 4; s++) begin
      arm("R2 arm");
      drive(0, 8'h00, 0, 1, 16'(s), 8'hFF, 0); step("R5 pointer map");
      idle("R3 rd_sel one cycle");
    end
    // R2: bit 7 ignored; another value does not open the window
    drive(1, 8'h89, 0, 0, 16'h0, 8'hFF, 0); step("R2 bit7 set");
    drive(0, 8'h00, 0, 1, 16'h1, 8'hFF, 0); step("R6 lock byte");
    drive(1, 8'h0B, 0, 0, 16'h0, 8'hFF, 0); step("R2 bad value");
    drive(0, 8'h00, 0, 1, 16'h0, 8'hFF, 0); step("R2 no window");
    // R3: load in cycle 3 accepted, cycle 4 refused
    arm("R3 arm"); idle("R3 wait"); idle("R3 wait");
    drive(0, 8'h00, 0, 1, 16'h3, 8'hFF, 0); step("R3 load cycle 3");
    arm("R3 arm"); idle("R3 wait"); idle("R3 wait"); idle("R3 wait");
    drive(0, 8'h00, 0, 1, 16'h0, 8'hFF, 0); step("R3 load cycle 4 refused");
    // R4: store in cycle 4 accepted, cycle 5 refused (R8 expiry)
    arm("R4 arm"); idle("R4 wait"); idle("R4 wait"); idle("R4 wait");
    drive(0, 8'h00, 1, 0, 16'h0, 8'hFB, 0); step("R4 store cycle 4");
    arm("R8 arm"); repeat (4) idle("R8 wait");
    drive(0, 8'h00, 1, 0, 16'h0, 8'hF7, 0); step("R8 store after expiry");
    // R8: second strobe after completion is ignored
    arm("R8 arm");
    drive(0, 8'h00, 0, 1, 16'h2, 8'hFF, 0); step("R8 first load");
    drive(0, 8'h00, 0, 1, 16'h2, 8'hFF, 0); step("R8 second load ignored");
    // R9: busy strobe ignored, window continues; arm during busy fails
    arm("R9 arm");
    drive(0, 8'h00, 0, 1, 16'h0, 8'hFF, 1); step("R9 busy load");
    drive(0, 8'h00, 1, 0, 16'h0, 8'hDF, 1); step("R9 busy store");
    drive(0, 8'h00, 0, 1, 16'h1, 8'hFF, 0); step("R9 load after busy");
    drive(1, 8'h09, 0, 0, 16'h0, 8'hFF, 1); step("R9 arm while busy");
    drive(0, 8'h00, 1, 0, 16'h0, 8'hDF, 0); step("R9 no window");
    // R5: out-of-range pointer refused, window stays open
    arm("R5 arm");
    drive(0, 8'h00, 0, 1, 16'h0104, 8'hFF, 0); step("R5 bad pointer");
    drive(0, 8'h00, 0, 1, 16'h0003, 8'hFF, 0); step("R5 retry pointer 3");
    // R10: re-arm restarts count
    arm("R10 arm"); idle("R10 wait"); idle("R10 wait");
    arm("R10 rearm"); idle("R10 wait"); idle("R10 wait"); idle("R10 wait");
    drive(0, 8'h00, 1, 0, 16'h0, 8'hEF, 0); step("R10 store cycle 4 after rearm");
    // R11: store beats load in the same cycle
    arm("R11 arm");
    drive(0, 8'h00, 1, 1, 16'h1, 8'hDF, 0); step("R11 collision");
    // R7: pointer ignored, general bits untouched
    arm("R7 arm");
    drive(0, 8'h00, 1, 0, 16'hFFFF, 8'h00, 0); step("R7 store all zero");
    arm("R7 arm");
    drive(0, 8'h00, 0, 1, 16'h1, 8'hFF, 0); step("R7 readback");

    // random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wd, lw;
      logic [15:0] p;
      wd = ($urandom % 3 != 0) ? {1'($urandom), 7'h09} : 8'($urandom);
      p  = ($urandom % 5 != 0) ? {14'h0, 2'($urandom)} : 16'($urandom);
      lw = ($urandom % 4 == 0) ? 8'($urandom) : (8'hFF ^ (8'h01 << ($urandom % 8)));
      drive(($urandom % 6) == 0, wd, ($urandom % 7) == 0, ($urandom % 3) == 0,
            p, lw, ($urandom % 8) == 0);
      step("R3 R4 R7 random");
      if (i % 700 == 699) do_reset();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule